// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Return-Address Stack

This block decides which interrupt request a small processor core services next. It also supplies the address of the service routine, and it holds the return addresses for interrupts and subroutine calls. The request sources are a reset request, a non-maskable line and eight maskable lines. The maskable lines are four external pins, serial receive, serial transmit, the timer and a software trap. Each maskable line has a sticky flag bit and an enable bit in the mask, and the CPU can load, set or clear either register. A global enable gates all maskable lines. It is cleared when an interrupt is taken and set again by a return-from-interrupt.

Vectors sit two words apart in a table. The table base is a 5-bit page pointer times 2048, so the table can be placed on any 2K-word page of the 64K space. An interrupt other than the reset request is granted only in a cycle where the core reports an instruction boundary and issues no call or return. The core holds the boundary signal low while a multicycle, repeated or wait-stated instruction is still running, so service waits until that instruction completes.

On a grant, the current program counter goes onto an eight-entry stack. The same stack serves plain calls. The cycle after a grant, a save strobe tells the core to copy key registers into their shadows. The cycle after a return-from-interrupt, a restore strobe tells the core to copy them back.

Top module: `irq_ctrl`

## Requirements
- R1: Priority is fixed. The reset request wins, then the non-maskable request, then maskable line 0 (external 1) down to line 7 (software trap). The source code on `src_o` is 0 for reset, 1 for the non-maskable request and 2+i for maskable line i.
- R2: The vector address is page*2048 + 2*code, with the page taken from the page register.
- R3: A maskable line is granted only when its flag bit, its mask bit and the global enable are all 1. The reset request and the non-maskable request ignore the mask and the global enable.
- R4: A high `irq_i[i]` sets flag bit i. A CPU write to register `sel` (0 mask, 1 flag, 2 page) applies `op`: 0 loads the data, 1 ORs it in, 2 clears the bits that are 1 in the data. The flag of a granted line is cleared.
- R5: A grant other than the reset request needs `boundary_i` high with `call_i`, `ret_i` and `reti_i` all low. Otherwise the request stays pending. The reset request is granted in any cycle.
- R6: A grant other than the reset request pushes `pc_i`, and so does `call_i`. `ret_i` and `reti_i` pop. `ret_addr_o` shows the most recent entry, in last-in first-out order.
- R7: A push onto a stack holding 8 entries overwrites the oldest entry. The depth stays 8, and `ovf_o` is high for the following cycle.
- R8: A grant clears the global enable, and `save_o` pulses in the next cycle. `reti_i` sets the global enable, and `restore_o` pulses in the next cycle.
- R9: A reset request grants vector 0x0000 and empties the stack. It also clears flags, mask, page and global enable.
- R10: After reset, flags, mask and page are 0, the global enable is 1, the stack is empty and no non-maskable request is pending.
- R11: The non-maskable request is captured on a rising edge of `nmi_i` and stays pending until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset interrupt request |
| nmi_i | input | 1 | Non-maskable request line |
| irq_i | input | NLINES | Maskable request pulses |
| boundary_i | input | 1 | Core is at an instruction boundary |
| pc_i | input | ADDR_W | Program counter to push |
| call_i | input | 1 | Subroutine call (push) |
| ret_i | input | 1 | Subroutine return (pop) |
| reti_i | input | 1 | Return from interrupt (pop, re-enable) |
| cpu_wr_i | input | 1 | CPU register write strobe |
| cpu_sel_i | input | 2 | Register select: 0 mask, 1 flag, 2 page |
| cpu_op_i | input | 2 | 0 load, 1 set bits, 2 clear bits |
| cpu_wdata_i | input | NLINES | Write data |
| flag_o | output | NLINES | Flag register |
| mask_o | output | NLINES | Mask register |
| page_o | output | PAGE_W | Vector page pointer |
| gie_o | output | 1 | Global enable |
| ack_o | output | 1 | Interrupt granted this cycle |
| src_o | output | SRC_W | Code of the granted source |
| vec_o | output | ADDR_W | Vector address of the grant |
| save_o | output | 1 | Shadow save strobe |
| restore_o | output | 1 | Shadow restore strobe |
| ret_addr_o | output | ADDR_W | Top of return stack |
| depth_o | output | CNT_W | Stack entries in use |
| ovf_o | output | 1 | Stack overflow pulse |

## Verification
The checker watches several relations on every cycle. A grant never leaves the global enable set. The strobes follow their causes by exactly one cycle. A maskable grant always has its flag and mask bit set. Vectors are even, and a reset grant lands at address 0. The stack never exceeds eight entries, and overflow appears only at full depth. Other behaviours need the bench's scenarios: the priority order across mixed pending sets, vector placement on a relocated page, the LIFO order of return addresses after an overflow has discarded the oldest entry, and the effect of a reset request on the stored state.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned DEF_LINES  = 8;
    localparam int unsigned DEF_DEPTH  = 8;
    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_PAGE_W = 5;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_KEEP = 2'd3
    } reg_op_e;

    // Apply a CPU register operation to a value of up to 32 bits.
    function automatic logic [31:0] apply_op(input logic [1:0] op,
                                             input logic [31:0] cur,
                                             input logic [31:0] wd);
        logic [31:0] res;
        case (op)
            OP_LOAD: res = wd;
            OP_SET:  res = cur | wd;
            OP_CLR:  res = cur & ~wd;
            default: res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int unsigned NLINES = DEF_LINES,
    parameter int unsigned PAGE_W = DEF_PAGE_W,
    localparam int unsigned SRC_W = $clog2(NLINES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_i,
    input  logic              nmi_i,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [1:0]        op_i,
    input  logic [NLINES-1:0] wdata_i,
    input  logic              grant_i,
    input  logic [SRC_W-1:0]  code_i,
    input  logic              reti_i,
    output logic [NLINES-1:0] flag_q,
    output logic [NLINES-1:0] mask_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              nmi_pend_q,
    output logic              gie_q
);

    logic              nmi_prev_q;
    logic              rst_grant;
    logic [NLINES-1:0] flag_d;
    logic [NLINES-1:0] mask_d;
    logic [PAGE_W-1:0] page_d;
    logic              nmi_d;

    assign rst_grant = grant_i && (code_i == '0);

    always_comb begin
        flag_d = flag_q;
        mask_d = mask_q;
        page_d = page_q;
        if (wr_i && sel_i == SEL_FLAG)
            flag_d = NLINES'(apply_op(op_i, 32'(flag_q), 32'(wdata_i)));
        if (wr_i && sel_i == SEL_MASK)
            mask_d = NLINES'(apply_op(op_i, 32'(mask_q), 32'(wdata_i)));
        if (wr_i && sel_i == SEL_PAGE)
            page_d = PAGE_W'(apply_op(op_i, 32'(page_q), 32'(wdata_i)));
        for (int i = 0; i < NLINES; i++) begin
            if (grant_i && code_i == SRC_W'(i + 2))
                flag_d[i] = 1'b0;
        end
        flag_d = flag_d | irq_i;
        if (rst_grant) begin
            flag_d = '0;
            mask_d = '0;
            page_d = '0;
        end
    end

    always_comb begin
        nmi_d = nmi_pend_q;
        if (grant_i && code_i == SRC_W'(1))
            nmi_d = 1'b0;
        if (nmi_i && !nmi_prev_q)
            nmi_d = 1'b1;
        if (rst_grant)
            nmi_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q     <= '0;
            mask_q     <= '0;
            page_q     <= '0;
            nmi_pend_q <= 1'b0;
            nmi_prev_q <= 1'b0;
            gie_q      <= 1'b1;
        end else begin
            flag_q     <= flag_d;
            mask_q     <= mask_d;
            page_q     <= page_d;
            nmi_pend_q <= nmi_d;
            nmi_prev_q <= nmi_i;
            if (grant_i)
                gie_q <= 1'b0;
            else if (reti_i)
                gie_q <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int unsigned NLINES = DEF_LINES,
    localparam int unsigned SRC_W = $clog2(NLINES + 2)
) (
    input  logic              rst_req_i,
    input  logic              nmi_pend_i,
    input  logic [NLINES-1:0] pending_i,
    input  logic              gie_i,
    input  logic              slot_ok_i,
    output logic              hit_o,
    output logic [SRC_W-1:0]  code_o
);

    always_comb begin
        hit_o  = 1'b0;
        code_o = '0;
        if (rst_req_i) begin
            hit_o  = 1'b1;
            code_o = '0;
        end else if (slot_ok_i) begin
            if (nmi_pend_i) begin
                hit_o  = 1'b1;
                code_o = SRC_W'(1);
            end else if (gie_i && |pending_i) begin
                hit_o = 1'b1;
                // scan downwards so the lowest index wins
                for (int i = NLINES - 1; i >= 0; i--) begin
                    if (pending_i[i])
                        code_o = SRC_W'(i + 2);
                end
            end
        end
    end

endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack
    import irq_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] din_i,
    output logic [ADDR_W-1:0] top_o,
    output logic [CNT_W-1:0]  depth_o,
    output logic              ovf_o
);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  sp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign top_o   = mem[sp_q - PTR_W'(1)];
    assign depth_o = cnt_q;

    // write slot wraps, so a push when full lands on the oldest entry
    always_ff @(posedge clk) begin
        if (push_i && !flush_i)
            mem[sp_q] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            cnt_q <= '0;
            ovf_o <= 1'b0;
        end else begin
            ovf_o <= 1'b0;
            if (flush_i) begin
                sp_q  <= '0;
                cnt_q <= '0;
            end else if (push_i) begin
                sp_q <= sp_q + PTR_W'(1);
                if (full)
                    ovf_o <= 1'b1;
                else
                    cnt_q <= cnt_q + CNT_W'(1);
            end else if (pop_i && cnt_q != '0) begin
                sp_q  <= sp_q - PTR_W'(1);
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NLINES = DEF_LINES,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned PAGE_W = DEF_PAGE_W,
    localparam int unsigned SRC_W      = $clog2(NLINES + 2),
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1),
    localparam int unsigned PAGE_SHIFT = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req_i,
    input  logic              nmi_i,
    input  logic [NLINES-1:0] irq_i,
    input  logic              boundary_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              reti_i,
    input  logic              cpu_wr_i,
    input  logic [1:0]        cpu_sel_i,
    input  logic [1:0]        cpu_op_i,
    input  logic [NLINES-1:0] cpu_wdata_i,
    output logic [NLINES-1:0] flag_o,
    output logic [NLINES-1:0] mask_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              gie_o,
    output logic              ack_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic              save_o,
    output logic              restore_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic [CNT_W-1:0]  depth_o,
    output logic              ovf_o
);

    logic             nmi_pend;
    logic             slot_ok;
    logic             hit;
    logic [SRC_W-1:0] code;
    logic             rst_grant;
    logic             push;
    logic             pop;

    assign slot_ok = boundary_i && !call_i && !ret_i && !reti_i;

    irq_regs #(.NLINES(NLINES), .PAGE_W(PAGE_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .irq_i      (irq_i),
        .nmi_i      (nmi_i),
        .wr_i       (cpu_wr_i),
        .sel_i      (cpu_sel_i),
        .op_i       (cpu_op_i),
        .wdata_i    (cpu_wdata_i),
        .grant_i    (hit),
        .code_i     (code),
        .reti_i     (reti_i),
        .flag_q     (flag_o),
        .mask_q     (mask_o),
        .page_q     (page_o),
        .nmi_pend_q (nmi_pend),
        .gie_q      (gie_o)
    );

    irq_arbiter #(.NLINES(NLINES)) arb_i (
        .rst_req_i  (rst_req_i),
        .nmi_pend_i (nmi_pend),
        .pending_i  (flag_o & mask_o),
        .gie_i      (gie_o),
        .slot_ok_i  (slot_ok),
        .hit_o      (hit),
        .code_o     (code)
    );

    assign rst_grant = hit && (code == '0);
    assign push      = (hit && !rst_grant) || call_i;
    assign pop       = ret_i || reti_i;

    irq_ret_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) stk_i (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .pop_i   (pop),
        .flush_i (rst_grant),
        .din_i   (pc_i),
        .top_o   (ret_addr_o),
        .depth_o (depth_o),
        .ovf_o   (ovf_o)
    );

    assign ack_o = hit;
    assign src_o = code;
    assign vec_o = rst_grant ? '0
                 : ({page_o, {PAGE_SHIFT{1'b0}}} | (ADDR_W'(code) << 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            save_o    <= 1'b0;
            restore_o <= 1'b0;
        end else begin
            save_o    <= hit;
            restore_o <= reti_i;
        end
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int unsigned NLINES = 8,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 5,
    localparam int unsigned SRC_W = $clog2(NLINES + 2),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              boundary_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              reti_i,
    input logic [NLINES-1:0] flag_o,
    input logic [NLINES-1:0] mask_o,
    input logic              gie_o,
    input logic              ack_o,
    input logic [SRC_W-1:0]  src_o,
    input logic [ADDR_W-1:0] vec_o,
    input logic              save_o,
    input logic              restore_o,
    input logic [CNT_W-1:0]  depth_o,
    input logic              ovf_o
);

    logic [SRC_W-1:0] line_idx;
    logic             maskable;
    assign line_idx = src_o - SRC_W'(2);
    assign maskable = ack_o && (src_o >= SRC_W'(2));

    AST_GRANT_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !gie_o); // R8
    AST_SAVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        save_o |-> $past(ack_o)); // R8
    AST_RESTORE_AFTER_RETI: assert property (@(posedge clk) disable iff (rst)
        restore_o |-> $past(reti_i)); // R8
    AST_MASKABLE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        maskable |-> (gie_o && flag_o[line_idx] && mask_o[line_idx])); // R3
    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (ack_o && src_o != '0) |-> (boundary_i && !call_i && !ret_i && !reti_i)); // R5
    AST_VEC_EVEN: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (vec_o[0] == 1'b0)); // R2
    AST_RESET_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ack_o && src_o == '0) |-> (vec_o == '0)); // R9
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        depth_o <= CNT_W'(DEPTH)); // R6
    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (depth_o == CNT_W'(DEPTH) && $past(depth_o) == CNT_W'(DEPTH))); // R7

endmodule

bind irq_ctrl irq_ctrl_chk #(
    .NLINES(NLINES), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .reti_i     (reti_i),
    .flag_o     (flag_o),
    .mask_o     (mask_o),
    .gie_o      (gie_o),
    .ack_o      (ack_o),
    .src_o      (src_o),
    .vec_o      (vec_o),
    .save_o     (save_o),
    .restore_o  (restore_o),
    .depth_o    (depth_o),
    .ovf_o      (ovf_o)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_req_i = 1'b0;
    logic        nmi_i = 1'b0;
    logic [7:0]  irq_i = '0;
    logic        boundary_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic        reti_i = 1'b0;
    logic        cpu_wr_i = 1'b0;
    logic [1:0]  cpu_sel_i = '0;
    logic [1:0]  cpu_op_i = '0;
    logic [7:0]  cpu_wdata_i = '0;
    logic [7:0]  flag_o, mask_o;
    logic [4:0]  page_o;
    logic        gie_o, ack_o, save_o, restore_o, ovf_o;
    logic [3:0]  src_o, depth_o;
    logic [15:0] vec_o, ret_addr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        logic [3:0]  src;
        logic [15:0] vec;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_i(nmi_i), .irq_i(irq_i),
        .boundary_i(boundary_i), .pc_i(pc_i), .call_i(call_i), .ret_i(ret_i),
        .reti_i(reti_i), .cpu_wr_i(cpu_wr_i), .cpu_sel_i(cpu_sel_i),
        .cpu_op_i(cpu_op_i), .cpu_wdata_i(cpu_wdata_i), .flag_o(flag_o),
        .mask_o(mask_o), .page_o(page_o), .gie_o(gie_o), .ack_o(ack_o),
        .src_o(src_o), .vec_o(vec_o), .save_o(save_o), .restore_o(restore_o),
        .ret_addr_o(ret_addr_o), .depth_o(depth_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: every grant must match the next expected item
    always @(negedge clk) begin
        if (!rst && ack_o) begin
            if (exp_q.size() == 0) begin
                chk("R3", "unexpected grant src", 32'(src_o), 32'hFFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "grant src", 32'(src_o), 32'(e.src));
                chk("R2", "grant vector", 32'(vec_o), 32'(e.vec));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [1:0] op, input logic [7:0] d);
        cpu_wr_i = 1'b1; cpu_sel_i = sel; cpu_op_i = op; cpu_wdata_i = d;
        tick();
        cpu_wr_i = 1'b0;
    endtask

    task automatic raise(input logic [7:0] lines, input bit nmi);
        irq_i = lines; nmi_i = nmi;
        tick();
        irq_i = '0; nmi_i = 1'b0;
    endtask

    task automatic take(input logic [15:0] pc, input logic [3:0] src,
                        input logic [15:0] vec, input string req);
        exp_t e;
        e.src = src; e.vec = vec; e.req = req;
        exp_q.push_back(e);
        boundary_i = 1'b1; pc_i = pc;
        tick();
        boundary_i = 1'b0;
    endtask

    task automatic no_ack(input bit bnd, input string req);
        boundary_i = bnd;
        #2;
        chk(req, "no grant expected", 32'(ack_o), 32'd0);
        tick();
        boundary_i = 1'b0;
    endtask

    task automatic do_reti();
        reti_i = 1'b1;
        tick();
        reti_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk("R10", "flag after reset", 32'(flag_o), 0);
        chk("R10", "mask after reset", 32'(mask_o), 0);
        chk("R10", "page after reset", 32'(page_o), 0);
        chk("R10", "gie after reset", 32'(gie_o), 1);
        chk("R10", "depth after reset", 32'(depth_o), 0);
        no_ack(1, "R10");

        cpu_write(2'd0, 2'd0, 8'hFF);
        cpu_write(2'd2, 2'd0, 8'h03);
        chk("R4", "mask load", 32'(mask_o), 32'hFF);
        chk("R4", "page load", 32'(page_o), 3);

        raise(8'h05, 0);
        chk("R4", "flags from lines", 32'(flag_o), 32'h05);
        no_ack(0, "R5");

        take(16'h1234, 4'd2, 16'h1804, "R1");
        chk("R4", "granted flag cleared", 32'(flag_o), 32'h04);
        chk("R8", "gie cleared", 32'(gie_o), 0);
        chk("R8", "save strobe", 32'(save_o), 1);
        chk("R6", "depth after grant", 32'(depth_o), 1);
        chk("R6", "pushed pc", 32'(ret_addr_o), 32'h1234);
        no_ack(1, "R3");

        raise(8'h00, 1);
        take(16'h2000, 4'd1, 16'h1802, "R11");
        chk("R6", "depth nested", 32'(depth_o), 2);
        chk("R6", "nested pc", 32'(ret_addr_o), 32'h2000);

        do_reti();
        chk("R6", "depth after reti", 32'(depth_o), 1);
        chk("R6", "top after reti", 32'(ret_addr_o), 32'h1234);
        chk("R8", "gie after reti", 32'(gie_o), 1);
        chk("R8", "restore strobe", 32'(restore_o), 1);

        take(16'h3000, 4'd4, 16'h1808, "R1");
        chk("R4", "flags empty", 32'(flag_o), 0);
        do_reti();
        ret_i = 1'b1; tick(); ret_i = 1'b0;
        chk("R6", "stack empty", 32'(depth_o), 0);

        cpu_write(2'd0, 2'd2, 8'h80);
        chk("R4", "mask clear op", 32'(mask_o), 32'h7F);
        raise(8'h80, 0);
        no_ack(1, "R3");
        chk("R3", "masked flag kept", 32'(flag_o), 32'h80);
        cpu_write(2'd1, 2'd2, 8'h80);
        chk("R4", "flag clear op", 32'(flag_o), 0);
        cpu_write(2'd1, 2'd1, 8'h40);
        chk("R4", "flag set op", 32'(flag_o), 32'h40);
        take(16'h4000, 4'd8, 16'h1810, "R4");
        do_reti();

        raise(8'h48, 0);
        take(16'h4100, 4'd5, 16'h180A, "R1");
        chk("R1", "lower line left pending", 32'(flag_o), 32'h40);
        do_reti();
        take(16'h4200, 4'd8, 16'h1810, "R1");
        do_reti();

        raise(8'h01, 1);
        take(16'h5000, 4'd1, 16'h1802, "R1");
        do_reti();
        take(16'h5100, 4'd2, 16'h1804, "R1");
        do_reti();
        chk("R6", "stack empty again", 32'(depth_o), 0);

        for (int k = 0; k < 9; k++) begin
            call_i = 1'b1; pc_i = 16'h0100 + 16'(k);
            tick();
            call_i = 1'b0;
            if (k == 7) chk("R7", "no overflow at 8", 32'(ovf_o), 0);
        end
        chk("R7", "overflow pulse", 32'(ovf_o), 1);
        chk("R7", "depth saturates", 32'(depth_o), 8);
        for (int k = 0; k < 8; k++) begin
            chk("R7", "lifo after overflow", 32'(ret_addr_o), 32'(16'h0108 - 16'(k)));
            ret_i = 1'b1; tick(); ret_i = 1'b0;
        end
        chk("R6", "drained", 32'(depth_o), 0);

        cpu_write(2'd2, 2'd0, 8'd31);
        cpu_write(2'd1, 2'd1, 8'h02);
        take(16'h0777, 4'd3, 16'hF806, "R2");
        chk("R6", "depth before reset request", 32'(depth_o), 1);
        cpu_write(2'd1, 2'd1, 8'h01);

        begin
            exp_t e;
            e.src = 4'd0; e.vec = 16'h0000; e.req = "R9";
            exp_q.push_back(e);
        end
        rst_req_i = 1'b1; tick(); rst_req_i = 1'b0;
        chk("R9", "stack flushed", 32'(depth_o), 0);
        chk("R9", "page cleared", 32'(page_o), 0);
        chk("R9", "mask cleared", 32'(mask_o), 0);
        chk("R9", "flags cleared", 32'(flag_o), 0);
        chk("R9", "gie cleared", 32'(gie_o), 0);

        tick();
        chk("R1", "all expected grants seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule